// File: doc/BRIEF.md
# Control-Flow Next-PC Unit

This block works out where the program counter goes after a control-flow instruction and how many cycles that instruction costs. The decode stage hands it a request with the current PC, a kind code and the operands the instruction needs: an offset field, an absolute target, a 16-bit pointer, a small extended-index register, the 8-bit status register, a bit index, two data operands for skip tests, and a flag that says whether the instruction after the current one is two words long. One clock edge later the unit returns the next PC, whether the flow left the straight line (`taken`), and the cycle count.

It covers unconditional relative, pointer-indirect, extended-indirect and absolute jumps. It also covers branches on one status bit being set or clear, signed greater-or-equal and less-than branches, and the skip family (skip when two operands are equal, or when a selected operand bit is clear or set). Bit skips on register bits and on I/O bits share one path: the caller places the register or I/O byte on `opnd_a`. Same-or-higher and lower branches are not separate kinds. They are the clear-bit and set-bit branches with the bit index set to 0, the carry position.

A two-state machine sequences the result. `S_IDLE` means no result is on the outputs. `S_DONE` means the outputs hold a fresh result for this cycle. Transition `T_ACCEPT` goes from either state to `S_DONE` when `req_valid` is high at a clock edge. Transition `T_DRAIN` goes from either state to `S_IDLE` when `req_valid` is low. Back-to-back requests keep the machine in `S_DONE`, and each edge loads a new result.

Top module: `npc_unit`

## Requirements
- R1: After reset, `out_valid`, `taken`, `next_pc` and `cycles` are all 0 and the state is `S_IDLE`.
- R2: A request taken at clock edge t gives `out_valid` = 1 after edge t, with the result of that request. If `req_valid` is low at an edge, `out_valid` is 0 after that edge.
- R3: Kind 1 (relative jump) gives `next_pc` = pc + sign-extended 12-bit `offset` + 1, with `taken` = 1 and `cycles` = 2.
- R4: Kind 2 (indirect) gives `next_pc` = zero-extended `zptr`. Kind 3 (extended indirect) gives `next_pc` = {`ext_idx`, `zptr`}. Both give `taken` = 1 and `cycles` = 2.
- R5: Kind 4 (absolute jump) gives `next_pc` = `target`, with `taken` = 1 and `cycles` = 3.
- R6: Kinds 5 and 6 branch when `sreg[bit_sel]` is 1 (kind 5) or 0 (kind 6). The status bits from bit 7 down are I, T, H, S, V, N, Z, C. When the branch is taken, `next_pc` = pc + sign-extended `offset[6:0]` + 1 and `cycles` = 2. When it is not taken, `next_pc` = pc + 1, `taken` = 0 and `cycles` = 1. With `bit_sel` = 0, kind 6 acts as same-or-higher and kind 5 acts as lower.
- R7: Kind 7 (signed greater-or-equal) branches when N (bit 2) XOR V (bit 3) is 0. Kind 8 (signed less-than) branches when it is 1. Targets and cycles are as in R6.
- R8: Kind 9 skips when `opnd_a` equals `opnd_b`.
- R9: Kind 10 skips when `opnd_a[bit_sel]` is 0. Kind 11 skips when it is 1.
- R10: For kinds 9 to 11, a skip gives `taken` = 1 with `next_pc` = pc + 2 and `cycles` = 2 when `next_two_word` = 0, or pc + 3 and `cycles` = 3 when it is 1. With no skip, the result is pc + 1, `taken` = 0 and `cycles` = 1.
- R11: Kind 0 and the unused codes 12 to 15 give pc + 1, `taken` = 0 and `cycles` = 1.
- R12: All PC additions wrap modulo 2^17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| kind | input | 4 | Control-flow kind code (see requirements) |
| pc_cur | input | 17 | Address of the current instruction |
| offset | input | 12 | Signed offset; branches use the low 7 bits |
| target | input | 17 | Absolute jump target |
| zptr | input | 16 | Pointer register used by the indirect forms |
| ext_idx | input | 1 | Extended-index bits placed above the pointer |
| sreg | input | 8 | Status register |
| bit_sel | input | 3 | Bit index for branches and bit skips |
| opnd_a | input | 8 | First skip operand, or the byte under bit test |
| opnd_b | input | 8 | Second skip operand for the equality skip |
| next_two_word | input | 1 | The following instruction is two words long |
| out_valid | output | 1 | Result valid (state `S_DONE`) |
| next_pc | output | 17 | Computed next program counter |
| taken | output | 1 | Flow left the straight line |
| cycles | output | 2 | Instruction cycle count |

## Verification
The bench builds the unit with its default parameters: a 17-bit PC, a 16-bit pointer, 7-bit branch offsets and 12-bit jump offsets. With these widths, directed cases can place the PC at 0x1FFFF and at 0, so wrap-around in both directions follows from small offsets. The 7-bit branch field reaches its extreme values of -64 and +63. The single extended-index bit selects the upper half of the address space. Random requests then cover every status bit index, both values of the two-word flag, and equal and unequal skip operands.

// File: rtl/npc_pkg.sv
package npc_pkg;
    typedef enum logic [3:0] {
        K_SEQ     = 4'd0,
        K_JREL    = 4'd1,
        K_JIND    = 4'd2,
        K_JEIND   = 4'd3,
        K_JABS    = 4'd4,
        K_BR_SET  = 4'd5,
        K_BR_CLR  = 4'd6,
        K_BR_GE   = 4'd7,
        K_BR_LT   = 4'd8,
        K_SK_EQ   = 4'd9,
        K_SK_BCLR = 4'd10,
        K_SK_BSET = 4'd11
    } kind_t;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_DONE = 1'b1
    } npc_state_t;

    localparam int unsigned BIT_V = 3;
    localparam int unsigned BIT_N = 2;
endpackage

// File: rtl/npc_cond.sv
module npc_cond
    import npc_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned SEL_W = $clog2(DATA_W)
) (
    input  logic [3:0]        kind,
    input  logic [DATA_W-1:0] sreg,
    input  logic [SEL_W-1:0]  bit_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic              cond_hit
);
    logic status_bit;
    logic operand_bit;
    logic signed_lt;

    assign status_bit  = sreg[bit_sel];
    assign operand_bit = opnd_a[bit_sel];
    assign signed_lt   = sreg[BIT_N] ^ sreg[BIT_V];

    always_comb begin
        unique case (kind)
            K_BR_SET:  cond_hit = status_bit;
            K_BR_CLR:  cond_hit = ~status_bit;
            K_BR_GE:   cond_hit = ~signed_lt;
            K_BR_LT:   cond_hit = signed_lt;
            K_SK_EQ:   cond_hit = (opnd_a == opnd_b);
            K_SK_BCLR: cond_hit = ~operand_bit;
            K_SK_BSET: cond_hit = operand_bit;
            default:   cond_hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/npc_target.sv
module npc_target #(
    parameter int unsigned PC_W     = 17,
    parameter int unsigned Z_W      = 16,
    parameter int unsigned BR_OFF_W = 7,
    parameter int unsigned RJ_OFF_W = 12,
    localparam int unsigned EXT_W   = PC_W - Z_W
) (
    input  logic [PC_W-1:0]     pc_cur,
    input  logic [RJ_OFF_W-1:0] offset,
    input  logic [Z_W-1:0]      zptr,
    input  logic [EXT_W-1:0]    ext_idx,
    output logic [PC_W-1:0]     pc_jrel,
    output logic [PC_W-1:0]     pc_brel,
    output logic [PC_W-1:0]     pc_ind,
    output logic [PC_W-1:0]     pc_eind,
    output logic [PC_W-1:0]     pc_step1,
    output logic [PC_W-1:0]     pc_step2,
    output logic [PC_W-1:0]     pc_step3
);
    logic [PC_W-1:0] jrel_ext;
    logic [PC_W-1:0] brel_ext;

    assign jrel_ext = {{(PC_W-RJ_OFF_W){offset[RJ_OFF_W-1]}}, offset};
    assign brel_ext = {{(PC_W-BR_OFF_W){offset[BR_OFF_W-1]}}, offset[BR_OFF_W-1:0]};

    assign pc_step1 = pc_cur + PC_W'(1);
    assign pc_step2 = pc_cur + PC_W'(2);
    assign pc_step3 = pc_cur + PC_W'(3);
    assign pc_jrel  = pc_step1 + jrel_ext;
    assign pc_brel  = pc_step1 + brel_ext;
    assign pc_ind   = {{EXT_W{1'b0}}, zptr};
    assign pc_eind  = {ext_idx, zptr};
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int unsigned PC_W     = 17,
    parameter int unsigned Z_W      = 16,
    parameter int unsigned BR_OFF_W = 7,
    parameter int unsigned RJ_OFF_W = 12,
    parameter int unsigned DATA_W   = 8,
    localparam int unsigned EXT_W   = PC_W - Z_W,
    localparam int unsigned SEL_W   = $clog2(DATA_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [3:0]          kind,
    input  logic [PC_W-1:0]     pc_cur,
    input  logic [RJ_OFF_W-1:0] offset,
    input  logic [PC_W-1:0]     target,
    input  logic [Z_W-1:0]      zptr,
    input  logic [EXT_W-1:0]    ext_idx,
    input  logic [DATA_W-1:0]   sreg,
    input  logic [SEL_W-1:0]    bit_sel,
    input  logic [DATA_W-1:0]   opnd_a,
    input  logic [DATA_W-1:0]   opnd_b,
    input  logic                next_two_word,
    output logic                out_valid,
    output logic [PC_W-1:0]     next_pc,
    output logic                taken,
    output logic [1:0]          cycles
);
    npc_state_t state_q, state_d;

    logic            cond_hit;
    logic [PC_W-1:0] pc_jrel, pc_brel, pc_ind, pc_eind;
    logic [PC_W-1:0] pc_step1, pc_step2, pc_step3;
    logic [PC_W-1:0] res_pc;
    logic            res_taken;
    logic [1:0]      res_cycles;

    npc_cond #(.DATA_W(DATA_W)) u_cond (
        .kind     (kind),
        .sreg     (sreg),
        .bit_sel  (bit_sel),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .cond_hit (cond_hit)
    );

    npc_target #(
        .PC_W(PC_W), .Z_W(Z_W), .BR_OFF_W(BR_OFF_W), .RJ_OFF_W(RJ_OFF_W)
    ) u_target (
        .pc_cur   (pc_cur),
        .offset   (offset),
        .zptr     (zptr),
        .ext_idx  (ext_idx),
        .pc_jrel  (pc_jrel),
        .pc_brel  (pc_brel),
        .pc_ind   (pc_ind),
        .pc_eind  (pc_eind),
        .pc_step1 (pc_step1),
        .pc_step2 (pc_step2),
        .pc_step3 (pc_step3)
    );

    // Result selection for the request on the inputs this cycle
    always_comb begin
        res_pc     = pc_step1;
        res_taken  = 1'b0;
        res_cycles = 2'd1;
        unique case (kind)
            K_JREL: begin
                res_pc = pc_jrel; res_taken = 1'b1; res_cycles = 2'd2;
            end
            K_JIND: begin
                res_pc = pc_ind; res_taken = 1'b1; res_cycles = 2'd2;
            end
            K_JEIND: begin
                res_pc = pc_eind; res_taken = 1'b1; res_cycles = 2'd2;
            end
            K_JABS: begin
                res_pc = target; res_taken = 1'b1; res_cycles = 2'd3;
            end
            K_BR_SET, K_BR_CLR, K_BR_GE, K_BR_LT: begin
                if (cond_hit) begin
                    res_pc = pc_brel; res_taken = 1'b1; res_cycles = 2'd2;
                end
            end
            K_SK_EQ, K_SK_BCLR, K_SK_BSET: begin
                if (cond_hit) begin
                    res_taken = 1'b1;
                    if (next_two_word) begin
                        res_pc = pc_step3; res_cycles = 2'd3;
                    end else begin
                        res_pc = pc_step2; res_cycles = 2'd2;
                    end
                end
            end
            default: begin
                res_pc = pc_step1; res_taken = 1'b0; res_cycles = 2'd1;
            end
        endcase
    end

    // Next-state logic: T_ACCEPT / T_DRAIN
    always_comb begin
        unique case (state_q)
            S_IDLE:  state_d = req_valid ? S_DONE : S_IDLE;
            S_DONE:  state_d = req_valid ? S_DONE : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            next_pc <= '0;
            taken   <= 1'b0;
            cycles  <= 2'd0;
        end else if (req_valid) begin
            next_pc <= res_pc;
            taken   <= res_taken;
            cycles  <= res_cycles;
        end
    end

    assign out_valid = (state_q == S_DONE);
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
    parameter int unsigned PC_W = 17
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [3:0]      kind,
    input logic [PC_W-1:0] pc_cur,
    input logic [PC_W-1:0] target,
    input logic            out_valid,
    input logic [PC_W-1:0] next_pc,
    input logic            taken,
    input logic [1:0]      cycles
);
    // R2: a request yields a valid result after the next edge
    p_valid_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    // R2: no request, no valid result
    p_idle_after_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);

    // R5: absolute jump loads the target in three cycles
    p_abs_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && kind == 4'd4) |=> (next_pc == $past(target) && cycles == 2'd3 && taken));

    // R11: straight-line kind advances by one word
    p_seq_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && kind == 4'd0) |=> (next_pc == $past(pc_cur) + PC_W'(1) && !taken && cycles == 2'd1));

    // R6: a result that is not taken costs one cycle
    p_not_taken_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !taken) |-> cycles == 2'd1);

    // R10: cycle count stays within 1..3 for every valid result
    p_cycles_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (cycles != 2'd0));
endmodule

bind npc_unit npc_unit_chk #(.PC_W(PC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .kind      (kind),
    .pc_cur    (pc_cur),
    .target    (target),
    .out_valid (out_valid),
    .next_pc   (next_pc),
    .taken     (taken),
    .cycles    (cycles)
);

// File: tb/npc_unit_tb.sv
module npc_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  kind = '0;
    logic [16:0] pc_cur = '0;
    logic [11:0] offset = '0;
    logic [16:0] target = '0;
    logic [15:0] zptr = '0;
    logic [0:0]  ext_idx = '0;
    logic [7:0]  sreg = '0;
    logic [2:0]  bit_sel = '0;
    logic [7:0]  opnd_a = '0;
    logic [7:0]  opnd_b = '0;
    logic        next_two_word = 1'b0;
    logic        out_valid;
    logic [16:0] next_pc;
    logic        taken;
    logic [1:0]  cycles;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    npc_unit u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .kind(kind),
        .pc_cur(pc_cur), .offset(offset), .target(target), .zptr(zptr),
        .ext_idx(ext_idx), .sreg(sreg), .bit_sel(bit_sel), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .next_two_word(next_two_word), .out_valid(out_valid),
        .next_pc(next_pc), .taken(taken), .cycles(cycles)
    );

    function automatic string tag_of(input logic [3:0] k);
        case (k)
            4'd1:         return "R3";
            4'd2, 4'd3:   return "R4";
            4'd4:         return "R5";
            4'd5, 4'd6:   return "R6";
            4'd7, 4'd8:   return "R7";
            4'd9:         return "R8";
            4'd10, 4'd11: return "R9";
            default:      return "R11";
        endcase
    endfunction

    // Reference model from the requirements: {next_pc, taken, cycles}
    function automatic logic [19:0] model(
        input logic [3:0] k, input logic [16:0] pc, input logic [11:0] off,
        input logic [16:0] tgt, input logic [15:0] z, input logic ex,
        input logic [7:0] sr, input logic [2:0] bs, input logic [7:0] a,
        input logic [7:0] b, input logic two);
        int        pci;
        logic      hit;
        pci = int'(pc);
        case (k)
            4'd1: return {17'((pci + int'($signed(off)) + 1) & 32'h1FFFF), 1'b1, 2'd2};
            4'd2: return {{1'b0, z}, 1'b1, 2'd2};
            4'd3: return {{ex, z}, 1'b1, 2'd2};
            4'd4: return {tgt, 1'b1, 2'd3};
            4'd5, 4'd6, 4'd7, 4'd8: begin
                if (k == 4'd5)      hit = sr[bs];
                else if (k == 4'd6) hit = !sr[bs];
                else if (k == 4'd7) hit = (sr[2] == sr[3]);
                else                hit = (sr[2] != sr[3]);
                if (hit) return {17'((pci + int'($signed(off[6:0])) + 1) & 32'h1FFFF), 1'b1, 2'd2};
                return {17'((pci + 1) & 32'h1FFFF), 1'b0, 2'd1};
            end
            4'd9, 4'd10, 4'd11: begin
                if (k == 4'd9)       hit = (a == b);
                else if (k == 4'd10) hit = !a[bs];
                else                 hit = a[bs];
                if (!hit) return {17'((pci + 1) & 32'h1FFFF), 1'b0, 2'd1};
                if (two)  return {17'((pci + 3) & 32'h1FFFF), 1'b1, 2'd3};
                return {17'((pci + 2) & 32'h1FFFF), 1'b1, 2'd2};
            end
            default: return {17'((pci + 1) & 32'h1FFFF), 1'b0, 2'd1};
        endcase
    endfunction

    task automatic check(input string tag, input logic [19:0] act, input logic [19:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s: pc/taken/cycles actual %h/%0b/%0d expected %h/%0b/%0d",
                     tag, act[19:3], act[2], act[1:0], exp_v[19:3], exp_v[2], exp_v[1:0]);
        end
    endtask

    task automatic issue(input logic [3:0] k, input logic [16:0] pc, input logic [11:0] off,
                         input logic [16:0] tgt, input logic [15:0] z, input logic ex,
                         input logic [7:0] sr, input logic [2:0] bs, input logic [7:0] a,
                         input logic [7:0] b, input logic two, input string tag);
        logic [19:0] exp_v;
        @(negedge clk);
        req_valid = 1'b1; kind = k; pc_cur = pc; offset = off; target = tgt;
        zptr = z; ext_idx = ex; sreg = sr; bit_sel = bs; opnd_a = a;
        opnd_b = b; next_two_word = two;
        exp_v = model(k, pc, off, tgt, z, ex, sr, bs, a, b, two);
        @(posedge clk); #1;
        n_chk++;
        if (out_valid !== 1'b1) begin
            n_bad++;
            $display("FAIL R2: out_valid actual %0b expected 1", out_valid);
        end
        check(tag, {next_pc, taken, cycles}, exp_v);
    endtask

    initial begin : watchdog
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        // R1: reset state
        #35;
        n_chk++;
        if ({out_valid, taken, next_pc, cycles} !== '0) begin
            n_bad++;
            $display("FAIL R1: outputs actual %0b/%0b/%h/%0d expected 0/0/0/0",
                     out_valid, taken, next_pc, cycles);
        end
        rst_n = 1'b1;

        // R3, R12: relative jump wraps both ways
        issue(4'd1, 17'h1FFFF, 12'h001, '0, '0, 0, '0, '0, '0, '0, 0, "R12");
        issue(4'd1, 17'h00000, 12'hFFE, '0, '0, 0, '0, '0, '0, '0, 0, "R12");
        issue(4'd1, 17'h00100, 12'h800, '0, '0, 0, '0, '0, '0, '0, 0, "R3");
        // R4: indirect and extended indirect
        issue(4'd2, 17'h00010, '0, '0, 16'hBEEF, 1, '0, '0, '0, '0, 0, "R4");
        issue(4'd3, 17'h00010, '0, '0, 16'hBEEF, 1, '0, '0, '0, '0, 0, "R4");
        // R5: absolute jump
        issue(4'd4, 17'h00020, '0, 17'h1ABCD, '0, 0, '0, '0, '0, '0, 0, "R5");
        // R6: branch extremes and carry aliases (bit 0)
        issue(4'd5, 17'h00040, 12'h040, '0, '0, 0, 8'h01, 3'd0, '0, '0, 0, "R6 lower taken");
        issue(4'd6, 17'h00040, 12'h03F, '0, '0, 0, 8'h01, 3'd0, '0, '0, 0, "R6 same-or-higher not taken");
        issue(4'd6, 17'h00040, 12'hF3F, '0, '0, 0, 8'hFE, 3'd0, '0, '0, 0, "R6 same-or-higher taken");
        issue(4'd5, 17'h00002, 12'h07F, '0, '0, 0, 8'h80, 3'd7, '0, '0, 0, "R6");
        // R7: signed compares
        issue(4'd7, 17'h00100, 12'h010, '0, '0, 0, 8'h0C, '0, '0, '0, 0, "R7");
        issue(4'd8, 17'h00100, 12'h010, '0, '0, 0, 8'h08, '0, '0, '0, 0, "R7");
        issue(4'd7, 17'h00100, 12'h010, '0, '0, 0, 8'h04, '0, '0, '0, 0, "R7");
        // R8, R9, R10: skips
        issue(4'd9, 17'h00200, '0, '0, '0, 0, '0, '0, 8'h5A, 8'h5A, 1, "R10");
        issue(4'd9, 17'h00200, '0, '0, '0, 0, '0, '0, 8'h5A, 8'h5B, 1, "R8");
        issue(4'd10, 17'h1FFFE, '0, '0, '0, 0, '0, 3'd4, 8'hEF, '0, 1, "R10");
        issue(4'd11, 17'h1FFFE, '0, '0, '0, 0, '0, 3'd4, 8'h10, '0, 0, "R9");
        issue(4'd11, 17'h00300, '0, '0, '0, 0, '0, 3'd4, 8'hEF, '0, 1, "R9");
        // R11: unused code
        issue(4'd14, 17'h1FFFF, '0, '0, '0, 0, '0, '0, '0, '0, 0, "R11");

        // R2: gap drops out_valid
        @(negedge clk); req_valid = 1'b0;
        @(posedge clk); #1;
        n_chk++;
        if (out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R2: out_valid actual %0b expected 0", out_valid);
        end

        // Random mix
        void'($urandom(32'd1234));
        for (int i = 0; i < 400; i++) begin
            logic [3:0] k;
            k = 4'($urandom_range(0, 15));
            issue(k, 17'($urandom), 12'($urandom), 17'($urandom), 16'($urandom),
                  1'($urandom), 8'($urandom), 3'($urandom), 8'($urandom_range(0, 3)),
                  8'($urandom_range(0, 3)), 1'($urandom), tag_of(k));
        end

        @(negedge clk); req_valid = 1'b0;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule